// File: doc/BRIEF.md
# Instruction Length and Conditional Skip Unit

This unit sits at the front of a small 16-bit processor pipeline. It takes the instruction word found at the current program counter and splits it into a 4-bit opcode and two 6-bit operand fields. From the operand modes it works out how many words the instruction occupies, from one to three. It owns the program counter, the stack pointer and the pending-skip flag. When the opcode is zero, the instruction uses the extended form. In that form the first operand field names an extended operation, and only the second field is an operand.

A conditional test instruction shows its outcome on `skip_req` and `cond_ok` in the cycle it is accepted. A failed test arms a skip. The next accepted instruction is then consumed without effect: the program counter steps over all of its words, and the skip clears. The extended subroutine call is handled here. It pushes the return address below the stack pointer and loads the counter with a target that the operand logic has already resolved. Any other extended code raises an illegal-instruction event. Executing the basic operations belongs to other blocks.

Top module: `ils_unit`

## Requirements
- R1: The opcode is bits 3:0 of the word, operand a is bits 9:4 and operand b is bits 15:10. These appear combinationally on `opc`, `opd_a` and `opd_b`.
- R2: `ins_len` is 1, plus 1 when operand b is in 0x10..0x17 or is 0x1E or 0x1F.
- R3: Operand a adds one more word for those same mode values only when the opcode is nonzero. When the opcode is 0, operand a never adds a word.
- R4: Each accepted, non-skipped instruction that is not a call moves `pc` forward by `ins_len` in the next cycle. With `ins_vld` low, `pc` and `sp` hold their values.
- R5: An executed instruction with `skip_req`=1 and `cond_ok`=0 sets `skip_pend`. The next accepted instruction is skipped: `skipped` is 1 in the following cycle, `pc` advances by that instruction's length, and `skip_pend` clears. With `cond_ok`=1 no skip is armed.
- R6: A skipped instruction's own `skip_req` is ignored, so skips never chain.
- R7: Opcode 0 sets `is_ext`=1 with `ext_op` equal to operand a. For any nonzero opcode, `is_ext`=0 and `ext_op`=0.
- R8: The extended call (code 0x01), when executed, decrements `sp` by one. In the next cycle `push_vld`=1, `push_addr` is the new `sp`, `push_data` is the old `pc` plus `ins_len`, `pc` equals `jsr_target`, and `xcyc` is 2. In every other cycle `push_vld` and `xcyc` are 0.
- R9: An executed extended instruction with any other code raises `ill_vld` for one cycle, with `ill_pc` set to that instruction's address. `pc` still advances by `ins_len`.
- R10: A skipped instruction produces no push, no change of `sp` and no illegal event.
- R11: Reset (`rst_n` low) sets `pc`=0 and `sp`=0, and clears `skip_pend`, `skipped`, `push_vld`, `ill_vld` and `xcyc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_vld | input | 1 | The word at `pc` is accepted this cycle |
| ins_word | input | 16 | Instruction word at `pc` |
| skip_req | input | 1 | The current instruction is a conditional test |
| cond_ok | input | 1 | Outcome of that test; 0 arms a skip |
| jsr_target | input | 16 | Resolved call target operand |
| opc | output | 4 | Opcode field |
| opd_a | output | 6 | Operand a field |
| opd_b | output | 6 | Operand b field |
| is_ext | output | 1 | Extended form selected |
| ext_op | output | 6 | Extended operation code, 0 when basic |
| ins_len | output | 2 | Instruction length in words |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| skip_pend | output | 1 | A skip is armed for the next instruction |
| skipped | output | 1 | The last accepted instruction was skipped |
| push_vld | output | 1 | Return-address push is issued |
| push_addr | output | 16 | Push address |
| push_data | output | 16 | Return address pushed |
| xcyc | output | 2 | Extra cycles charged to the last instruction |
| ill_vld | output | 1 | Illegal extended operation event |
| ill_pc | output | 16 | Address of the illegal instruction |

## Verification
Two functions can meet in one cycle: consuming an armed skip, and the effects of the instruction being consumed. That instruction may carry its own failed test, a call, or a reserved extended code. The bench arms a skip and then presents each of these as the victim. It checks three things. First, `pc` moves by exactly the victim's length and no further. Second, `skip_pend` ends clear rather than being re-armed. Third, `sp`, `push_vld` and `ill_vld` show no trace of the skipped call or the skipped reserved code.

// File: rtl/ils_pkg.sv
package ils_pkg;
    // Operand modes that pull one extra word from the instruction stream
    localparam int ILS_IDX_LO  = 16;
    localparam int ILS_IDX_HI  = 23;
    localparam int ILS_NXT_IND = 30;
    localparam int ILS_NXT_LIT = 31;

    // Kind of extended-form operation
    typedef enum logic [1:0] {
        EK_NONE = 2'd0,
        EK_JSR  = 2'd1,
        EK_RSVD = 2'd2
    } ext_kind_t;
endpackage

// File: rtl/ils_opd_words.sv
module ils_opd_words
    import ils_pkg::*;
#(
    parameter int OPD_W = 6
) (
    input  logic [OPD_W-1:0] mode,
    input  logic             en,
    output logic             extra
);
    logic in_idx;
    logic in_nxt;

    always_comb begin
        in_idx = (int'(mode) >= ILS_IDX_LO) && (int'(mode) <= ILS_IDX_HI);
        in_nxt = (int'(mode) == ILS_NXT_IND) || (int'(mode) == ILS_NXT_LIT);
        extra  = en && (in_idx || in_nxt);
    end
endmodule

// File: rtl/ils_split.sv
module ils_split #(
    parameter int OPC_W = 4,
    parameter int OPD_W = 6,
    parameter int LEN_W = 2,
    localparam int WORD_W = OPC_W + 2 * OPD_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [OPC_W-1:0]  opc,
    output logic [OPD_W-1:0]  opd_a,
    output logic [OPD_W-1:0]  opd_b,
    output logic              is_ext,
    output logic [LEN_W-1:0]  len
);
    localparam int N_OPD = 2;

    logic [OPD_W-1:0] mode_arr [N_OPD];
    logic             en_arr   [N_OPD];
    logic [N_OPD-1:0] extra;

    always_comb begin
        opc         = word[OPC_W-1:0];
        opd_a       = word[OPC_W+OPD_W-1:OPC_W];
        opd_b       = word[WORD_W-1:OPC_W+OPD_W];
        is_ext      = (opc == '0);
        mode_arr[0] = opd_a;
        mode_arr[1] = opd_b;
        en_arr[0]   = !is_ext;   // extended form has no a operand
        en_arr[1]   = 1'b1;
    end

    for (genvar i = 0; i < N_OPD; i++) begin : g_opd
        ils_opd_words #(.OPD_W(OPD_W)) u_words (
            .mode  (mode_arr[i]),
            .en    (en_arr[i]),
            .extra (extra[i])
        );
    end

    always_comb begin
        len = LEN_W'(1);
        for (int k = 0; k < N_OPD; k++) begin
            len = len + LEN_W'(extra[k]);
        end
    end
endmodule

// File: rtl/ils_ext_disp.sv
module ils_ext_disp
    import ils_pkg::*;
#(
    parameter int OPD_W    = 6,
    parameter int JSR_CODE = 1
) (
    input  logic             is_ext,
    input  logic [OPD_W-1:0] opd_a,
    output logic [OPD_W-1:0] ext_op,
    output ext_kind_t        kind
);
    always_comb begin
        ext_op = is_ext ? opd_a : '0;
        if (!is_ext) begin
            kind = EK_NONE;
        end else if (opd_a == OPD_W'(JSR_CODE)) begin
            kind = EK_JSR;
        end else begin
            kind = EK_RSVD;
        end
    end
endmodule

// File: rtl/ils_unit.sv
module ils_unit
    import ils_pkg::*;
#(
    parameter int OPC_W    = 4,
    parameter int OPD_W    = 6,
    parameter int LEN_W    = 2,
    parameter int JSR_CODE = 1,
    parameter int JSR_CYC  = 2,
    localparam int WORD_W  = OPC_W + 2 * OPD_W,
    localparam int XCYC_W  = $clog2(JSR_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_vld,
    input  logic [WORD_W-1:0] ins_word,
    input  logic              skip_req,
    input  logic              cond_ok,
    input  logic [WORD_W-1:0] jsr_target,
    output logic [OPC_W-1:0]  opc,
    output logic [OPD_W-1:0]  opd_a,
    output logic [OPD_W-1:0]  opd_b,
    output logic              is_ext,
    output logic [OPD_W-1:0]  ext_op,
    output logic [LEN_W-1:0]  ins_len,
    output logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] sp,
    output logic              skip_pend,
    output logic              skipped,
    output logic              push_vld,
    output logic [WORD_W-1:0] push_addr,
    output logic [WORD_W-1:0] push_data,
    output logic [XCYC_W-1:0] xcyc,
    output logic              ill_vld,
    output logic [WORD_W-1:0] ill_pc
);
    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] sp;
        logic              skip;
        logic              skipped;
        logic              push_vld;
        logic [WORD_W-1:0] push_addr;
        logic [WORD_W-1:0] push_data;
        logic [XCYC_W-1:0] xcyc;
        logic              ill_vld;
        logic [WORD_W-1:0] ill_pc;
    } st_t;

    st_t       st_d;
    st_t       st_q;
    ext_kind_t kind;
    logic [WORD_W-1:0] ret_addr;

    ils_split #(.OPC_W(OPC_W), .OPD_W(OPD_W), .LEN_W(LEN_W)) u_split (
        .word   (ins_word),
        .opc    (opc),
        .opd_a  (opd_a),
        .opd_b  (opd_b),
        .is_ext (is_ext),
        .len    (ins_len)
    );

    ils_ext_disp #(.OPD_W(OPD_W), .JSR_CODE(JSR_CODE)) u_disp (
        .is_ext (is_ext),
        .opd_a  (opd_a),
        .ext_op (ext_op),
        .kind   (kind)
    );

    always_comb begin
        ret_addr      = st_q.pc + WORD_W'(ins_len);
        st_d          = st_q;
        st_d.skipped  = 1'b0;
        st_d.push_vld = 1'b0;
        st_d.ill_vld  = 1'b0;
        st_d.xcyc     = '0;
        if (ins_vld) begin
            if (st_q.skip) begin
                // consume the whole instruction, no side effects
                st_d.pc      = ret_addr;
                st_d.skip    = 1'b0;
                st_d.skipped = 1'b1;
            end else begin
                st_d.pc = ret_addr;
                if (kind == EK_JSR) begin
                    st_d.sp        = st_q.sp - WORD_W'(1);
                    st_d.push_vld  = 1'b1;
                    st_d.push_addr = st_q.sp - WORD_W'(1);
                    st_d.push_data = ret_addr;
                    st_d.pc        = jsr_target;
                    st_d.xcyc      = XCYC_W'(JSR_CYC);
                end
                if (kind == EK_RSVD) begin
                    st_d.ill_vld = 1'b1;
                    st_d.ill_pc  = st_q.pc;
                end
                if (skip_req && !cond_ok) begin
                    st_d.skip = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pc        = st_q.pc;
        sp        = st_q.sp;
        skip_pend = st_q.skip;
        skipped   = st_q.skipped;
        push_vld  = st_q.push_vld;
        push_addr = st_q.push_addr;
        push_data = st_q.push_data;
        xcyc      = st_q.xcyc;
        ill_vld   = st_q.ill_vld;
        ill_pc    = st_q.ill_pc;
    end
endmodule

// File: rtl/ils_unit_chk.sv
module ils_unit_chk #(
    parameter int OPC_W   = 4,
    parameter int OPD_W   = 6,
    parameter int LEN_W   = 2,
    parameter int WORD_W  = 16,
    parameter int XCYC_W  = 2,
    parameter int JSR_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_vld,
    input logic [OPC_W-1:0]  opc,
    input logic [OPD_W-1:0]  opd_b,
    input logic              is_ext,
    input logic [OPD_W-1:0]  ext_op,
    input logic [LEN_W-1:0]  ins_len,
    input logic [WORD_W-1:0] pc,
    input logic [WORD_W-1:0] sp,
    input logic              skip_pend,
    input logic              skipped,
    input logic              push_vld,
    input logic [WORD_W-1:0] push_addr,
    input logic [XCYC_W-1:0] xcyc,
    input logic              ill_vld
);
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_vld |=> ($stable(pc) && $stable(sp)));

    // R3
    ext_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == '0 && int'(opd_b) < 16) |-> (ins_len == LEN_W'(1)));

    // R7
    basic_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ext |-> (ext_op == '0));

    // R6
    skip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skipped |-> !skip_pend);

    // R10
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skipped |-> (!push_vld && !ill_vld && $stable(sp)));

    // R8
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld |-> (push_addr == sp && xcyc == XCYC_W'(JSR_CYC)));

    // R8
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_vld) |-> (sp == $past(sp) - WORD_W'(1)));

    // R9
    ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ill_vld |-> !push_vld);
endmodule

bind ils_unit ils_unit_chk #(
    .OPC_W(OPC_W), .OPD_W(OPD_W), .LEN_W(LEN_W),
    .WORD_W(WORD_W), .XCYC_W(XCYC_W), .JSR_CYC(JSR_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .opc(opc), .opd_b(opd_b),
    .is_ext(is_ext), .ext_op(ext_op), .ins_len(ins_len), .pc(pc), .sp(sp),
    .skip_pend(skip_pend), .skipped(skipped), .push_vld(push_vld),
    .push_addr(push_addr), .xcyc(xcyc), .ill_vld(ill_vld)
);

// File: tb/ils_unit_test.sv
module ils_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_vld = 1'b0;
    logic [15:0] ins_word = '0;
    logic        skip_req = 1'b0;
    logic        cond_ok = 1'b0;
    logic [15:0] jsr_target = '0;
    logic [3:0]  opc;
    logic [5:0]  opd_a, opd_b, ext_op;
    logic        is_ext, skip_pend, skipped, push_vld, ill_vld;
    logic [1:0]  ins_len, xcyc;
    logic [15:0] pc, sp, push_addr, push_data, ill_pc;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_pc = '0;

    ils_unit uut (
        .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_word(ins_word),
        .skip_req(skip_req), .cond_ok(cond_ok), .jsr_target(jsr_target),
        .opc(opc), .opd_a(opd_a), .opd_b(opd_b), .is_ext(is_ext),
        .ext_op(ext_op), .ins_len(ins_len), .pc(pc), .sp(sp),
        .skip_pend(skip_pend), .skipped(skipped), .push_vld(push_vld),
        .push_addr(push_addr), .push_data(push_data), .xcyc(xcyc),
        .ill_vld(ill_vld), .ill_pc(ill_pc)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] mk(input logic [3:0] o, input logic [5:0] a, input logic [5:0] b);
        return {b, a, o};
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // present one instruction at a falling edge, return at the next falling edge
    task automatic issue(input logic [15:0] w, input logic sreq, input logic cok, input logic [15:0] tgt);
        ins_word   = w;
        skip_req   = sreq;
        cond_ok    = cok;
        jsr_target = tgt;
        ins_vld    = 1'b1;
        @(negedge clk);
        ins_vld    = 1'b0;
        skip_req   = 1'b0;
        cond_ok    = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "pc", pc, 16'h0);
        chk("R11", "sp", sp, 16'h0);
        chk("R11", "skip_pend", {15'b0, skip_pend}, 16'h0);
        chk("R11", "events", {12'b0, skipped, push_vld, ill_vld, |xcyc}, 16'h0);
        rst_n = 1'b1;
        exp_pc = '0;
        @(negedge clk);
    endtask

    task automatic t_fields();
        ins_word = mk(4'hA, 6'h15, 6'h2C);
        #1;
        chk("R1", "opc", {12'b0, opc}, 16'hA);
        chk("R1", "opd_a", {10'b0, opd_a}, 16'h15);
        chk("R1", "opd_b", {10'b0, opd_b}, 16'h2C);
        chk("R7", "basic is_ext/ext_op", {9'b0, is_ext, ext_op}, 16'h0);
        ins_word = mk(4'h0, 6'h01, 6'h00);
        #1;
        chk("R7", "ext is_ext/ext_op", {9'b0, is_ext, ext_op}, {9'b0, 1'b1, 6'h01});
        @(negedge clk);
        chk("R4", "pc held without ins_vld", pc, exp_pc);
    endtask

    task automatic len_case(input string req, input logic [15:0] w, input logic [1:0] exp);
        ins_word = w;
        #1;
        chk(req, $sformatf("len of %h", w), {14'b0, ins_len}, {14'b0, exp});
    endtask

    task automatic t_lengths();
        len_case("R2", mk(4'h1, 6'h00, 6'h00), 2'd1);
        len_case("R3", mk(4'h1, 6'h10, 6'h00), 2'd2);
        len_case("R2", mk(4'h1, 6'h17, 6'h1F), 2'd3);
        len_case("R2", mk(4'h1, 6'h18, 6'h1E), 2'd2);
        len_case("R3", mk(4'h2, 6'h1E, 6'h1F), 2'd3);
        len_case("R2", mk(4'h1, 6'h0F, 6'h18), 2'd1);
        len_case("R3", mk(4'h0, 6'h1F, 6'h00), 2'd1);
        len_case("R3", mk(4'h0, 6'h10, 6'h12), 2'd2);
        @(negedge clk);
    endtask

    task automatic t_step();
        issue(mk(4'h1, 6'h1F, 6'h10), 1'b0, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd3;
        chk("R4", "pc after 3-word", pc, exp_pc);
        issue(mk(4'h1, 6'h00, 6'h00), 1'b0, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd1;
        chk("R4", "pc after 1-word", pc, exp_pc);
        repeat (2) @(negedge clk);
        chk("R4", "pc idle", pc, exp_pc);
    endtask

    task automatic t_skip();
        issue(mk(4'hC, 6'h00, 6'h00), 1'b1, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd1;
        chk("R5", "armed", {15'b0, skip_pend}, 16'h1);
        issue(mk(4'h1, 6'h1E, 6'h1F), 1'b0, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd3;
        chk("R5", "skipped flag", {15'b0, skipped}, 16'h1);
        chk("R5", "pc past 3-word victim", pc, exp_pc);
        chk("R5", "skip cleared", {15'b0, skip_pend}, 16'h0);
        issue(mk(4'hC, 6'h00, 6'h00), 1'b1, 1'b1, 16'h0);
        exp_pc = exp_pc + 16'd1;
        chk("R5", "true test no arm", {15'b0, skip_pend}, 16'h0);
        issue(mk(4'h1, 6'h00, 6'h10), 1'b0, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd2;
        chk("R5", "executed after true test", {15'b0, skipped}, 16'h0);
        chk("R5", "pc after true test", pc, exp_pc);
    endtask

    task automatic t_chain();
        issue(mk(4'hC, 6'h00, 6'h00), 1'b1, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd1;
        issue(mk(4'hD, 6'h10, 6'h00), 1'b1, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd2;
        chk("R6", "skipped test", {15'b0, skipped}, 16'h1);
        chk("R6", "no re-arm", {15'b0, skip_pend}, 16'h0);
        chk("R6", "pc", pc, exp_pc);
        issue(mk(4'h1, 6'h00, 6'h00), 1'b0, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd1;
        chk("R6", "following runs", {15'b0, skipped}, 16'h0);
    endtask

    task automatic t_jsr();
        logic [15:0] old_sp;
        old_sp = sp;
        issue(mk(4'h0, 6'h01, 6'h1F), 1'b0, 1'b0, 16'h0400);
        chk("R8", "push_vld", {15'b0, push_vld}, 16'h1);
        chk("R8", "sp dec", sp, old_sp - 16'd1);
        chk("R8", "push_addr", push_addr, old_sp - 16'd1);
        chk("R8", "push_data", push_data, exp_pc + 16'd2);
        chk("R8", "pc target", pc, 16'h0400);
        chk("R8", "xcyc", {14'b0, xcyc}, 16'd2);
        exp_pc = 16'h0400;
        issue(mk(4'h1, 6'h00, 6'h00), 1'b0, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd1;
        chk("R8", "push drops", {13'b0, push_vld, xcyc}, 16'h0);
        chk("R8", "pc after", pc, exp_pc);
    endtask

    task automatic t_illegal();
        logic [15:0] old_sp;
        old_sp = sp;
        issue(mk(4'h0, 6'h02, 6'h12), 1'b0, 1'b0, 16'h0);
        chk("R9", "ill_vld", {15'b0, ill_vld}, 16'h1);
        chk("R9", "ill_pc", ill_pc, exp_pc);
        exp_pc = exp_pc + 16'd2;
        chk("R9", "pc", pc, exp_pc);
        chk("R9", "no push/sp", {push_vld, sp[14:0]}, {1'b0, old_sp[14:0]});
        issue(mk(4'h0, 6'h00, 6'h00), 1'b0, 1'b0, 16'h0);
        chk("R9", "ill_pc code0", ill_pc, exp_pc);
        exp_pc = exp_pc + 16'd1;
        chk("R9", "pc code0", pc, exp_pc);
        @(negedge clk);
        chk("R9", "pulse ends", {15'b0, ill_vld}, 16'h0);
    endtask

    task automatic t_skip_quiet();
        logic [15:0] old_sp;
        old_sp = sp;
        issue(mk(4'hE, 6'h00, 6'h00), 1'b1, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd1;
        issue(mk(4'h0, 6'h01, 6'h10), 1'b0, 1'b0, 16'h0700);
        exp_pc = exp_pc + 16'd2;
        chk("R10", "skipped call no push", {15'b0, push_vld}, 16'h0);
        chk("R10", "skipped call sp", sp, old_sp);
        chk("R10", "skipped call pc", pc, exp_pc);
        issue(mk(4'hE, 6'h00, 6'h00), 1'b1, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd1;
        issue(mk(4'h0, 6'h05, 6'h00), 1'b0, 1'b0, 16'h0);
        exp_pc = exp_pc + 16'd1;
        chk("R10", "skipped reserved no event", {15'b0, ill_vld}, 16'h0);
        chk("R10", "skipped reserved pc", pc, exp_pc);
    endtask

    task automatic t_reset_mid();
        issue(mk(4'hC, 6'h00, 6'h00), 1'b1, 1'b0, 16'h0);
        chk("R11", "armed before reset", {15'b0, skip_pend}, 16'h1);
        t_reset();
        chk("R11", "state after reset", {15'b0, skip_pend}, 16'h0);
    endtask

    initial begin
        #(8 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fields();
        t_lengths();
        t_step();
        t_skip();
        t_chain();
        t_jsr();
        t_illegal();
        t_skip_quiet();
        t_reset_mid();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule